// File: doc/BRIEF.md
# Serial SAR Converter Sequencer

This block is the host-side sequencer for a four-wire serial successive-approximation converter that runs from an external serial clock. On a start request it pulls chip select low and shifts a control byte out MSB first on the serial data line. The byte carries the input channel, the polarity, the input mode and the power-mode bits. The block keeps clocking while it waits for the converter's strobe line to fall. It then captures a 16-clock reply, keeps the 12 leading bits (a 10-bit result plus two sub-LSB bits) and drops the 4 trailing bits. Chip select goes high again after the reply.

A scan request converts all eight channels in ascending order. Each result goes into a per-channel result register, with no host action between conversions. The serial clock is the system clock divided by a parameter. With the default settings and a 200 MHz system clock it runs at 2 MHz. The strobe input is synchronised before its falling edge is detected. If no falling edge arrives within a parameterised number of serial clocks, the conversion is aborted and flagged.

Top module: `serial_adc_ctl`

## Requirements
- R1: After reset, chip select is high, the serial clock and data out are low, busy, done, scan_done and timeout are low, and the result and every result register read zero.
- R2: The control byte is sent MSB first as bit7=1, bits6:4=channel, bit3=unipolar, bit2=single-ended, bits1:0=11. In scan mode the channel field is the scan index.
- R3: The serial clock idles low whenever chip select is high. Chip select falls before the first rising clock edge. Each clock half-period is DIV_HALF system cycles. Data out changes only on falling clock edges, so the converter samples it on rising edges.
- R4: After the control byte the block keeps clocking and waits for a synchronised falling edge on the strobe. It then samples data in on the next 16 rising edges. The first bit captured becomes result bit 11, the 12th becomes bit 0, and the last 4 are discarded.
- R5: At the falling clock edge after the 16th capture, chip select rises, busy falls and done pulses for exactly one system cycle. result_o changes only in the cycle in which chip select rises.
- R6: A start request is ignored while busy: it does not change the channel, the control byte or the number of conversions.
- R7: Timeout is declared at the TIMEOUT_SCLKS-th rising clock edge of the wait when no strobe fall has been seen by then. The conversion is then released with done and timeout_o high. The result and the result registers are left unchanged, a running scan stops, and timeout_o clears on the next accepted start. A strobe fall seen before that edge, even one arriving in the last half-period, is accepted.
- R8: A scan converts channels 0 to 7 in order, with chip select high between conversions. scan_done pulses together with the single done at the end.
- R9: Every successful conversion writes its 12-bit result into the result register indexed by its channel. rf_rd_data_o shows the register selected by rf_rd_idx_i without delay.
- R10: Busy is high from the accepted start until chip select is released for the last time, and it stays high across a whole scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled when idle |
| scan_i | input | 1 | With start: convert all channels |
| chan_i | input | 3 | Channel for a single conversion |
| unipolar_i | input | 1 | Unipolar coding select |
| single_ended_i | input | 1 | Single-ended input select |
| rf_rd_idx_i | input | 3 | Result register read index |
| busy_o | output | 1 | Conversion or scan in progress |
| done_o | output | 1 | One-cycle pulse at end of request |
| scan_done_o | output | 1 | One-cycle pulse at end of a completed scan |
| timeout_o | output | 1 | Last request aborted on missing strobe |
| result_o | output | 12 | Latest converted value |
| rf_rd_data_o | output | 12 | Result register selected by rf_rd_idx_i |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_sclk_o | output | 1 | Serial clock to converter |
| adc_din_o | output | 1 | Serial data to converter |
| adc_sstrb_i | input | 1 | Converter strobe, asynchronous |
| adc_dout_i | input | 1 | Serial data from converter |

## Verification
The bench models the converter. It decodes every control byte from the pins and answers with random 12-bit values followed by random trailing bits. A design that kept the trailing bits or got the bit order wrong would return a shifted or reversed result. The strobe delay is swept up to the exact timeout boundary, where a counter that is off by one would abort a valid conversion. A run with the strobe never falling checks that the result and the result registers survive a timeout. A start pulse during a conversion checks that only one control byte is sent. A scan checks the order of the channel fields and every result register, which catches a missed increment or a write to the wrong index.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int CTRL_W  = 8;
    localparam int FRAME_W = 16;
    localparam int RES_W   = 12;
    localparam int CH_W    = 3;
    localparam int NUM_CH  = 1 << CH_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_READ,
        ST_FINISH,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            unipolar;
        logic            single_ended;
    } conv_cfg_t;

    // Start flag, channel, coding, input mode, external-clock power mode.
    function automatic logic [CTRL_W-1:0] build_ctrl(conv_cfg_t c);
        return {1'b1, c.chan, c.unipolar, c.single_ended, 2'b11};
    endfunction

endpackage

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen #(
    parameter int DIV_HALF = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (DIV_HALF < 2) ? 1 : $clog2(DIV_HALF);

    logic [CW-1:0] cnt_q;
    logic          sclk_q;
    logic          terminal;

    assign terminal = (cnt_q == CW'(DIV_HALF - 1));
    assign rise_o   = en_i && terminal && !sclk_q;
    assign fall_o   = en_i && terminal &&  sclk_q;
    assign sclk_o   = sclk_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (terminal) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    sclk_park_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !sclk_o);

endmodule

// File: rtl/sadc_edge_sync.sv
module sadc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall_o = prev_q && !sync_q[STAGES-1];

    // R4
    strobe_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/sadc_result_bank.sv
module sadc_result_bank #(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we_i,
    input  logic [$clog2(NUM_CH)-1:0] waddr_i,
    input  logic [RES_W-1:0]          wdata_i,
    input  logic [$clog2(NUM_CH)-1:0] raddr_i,
    output logic [RES_W-1:0]          rdata_o
);
    logic [RES_W-1:0] entry_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= '0;
            end else if (we_i && (waddr_i == g)) begin
                entry_q[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = entry_q[raddr_i];

endmodule

// File: rtl/serial_adc_ctl.sv
module serial_adc_ctl
    import sadc_pkg::*;
#(
    parameter int DIV_HALF      = 50,
    parameter int TIMEOUT_SCLKS = 64,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             scan_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic             unipolar_i,
    input  logic             single_ended_i,
    input  logic [CH_W-1:0]  rf_rd_idx_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             scan_done_o,
    output logic             timeout_o,
    output logic [RES_W-1:0] result_o,
    output logic [RES_W-1:0] rf_rd_data_o,
    output logic             adc_cs_n_o,
    output logic             adc_sclk_o,
    output logic             adc_din_o,
    input  logic             adc_sstrb_i,
    input  logic             adc_dout_i
);
    localparam int BIT_W = $clog2(FRAME_W);
    localparam int TO_W  = $clog2(TIMEOUT_SCLKS + 1);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    seq_state_e         state_q;
    conv_cfg_t          cfg_q, start_cfg;
    logic               scan_q, fail_q, timeout_q, done_q, scan_done_q;
    logic               cs_n_q, din_q;
    logic [CTRL_W-1:0]  ctrl_sr_q, start_ctrl, next_ctrl;
    logic [BIT_W-1:0]   bit_cnt_q;
    logic [TO_W-1:0]    to_cnt_q;
    logic [FRAME_W-1:0] frame_q;
    logic [RES_W-1:0]   result_q;
    logic               sclk_en, sclk_rise, sclk_fall, strobe_fall, bank_we;

    always_comb begin
        start_cfg.chan         = scan_i ? '0 : chan_i;
        start_cfg.unipolar     = unipolar_i;
        start_cfg.single_ended = single_ended_i;
    end

    assign start_ctrl = build_ctrl(start_cfg);
    assign next_ctrl  = build_ctrl(cfg_q);
    assign sclk_en    = (state_q == ST_SEND) || (state_q == ST_WAIT) ||
                        (state_q == ST_READ) || (state_q == ST_FINISH);
    assign bank_we    = (state_q == ST_FINISH) && sclk_fall && !fail_q;

    sadc_sclk_gen #(.DIV_HALF(DIV_HALF)) u_sclk (
        .clk(clk), .rst(rst), .en_i(sclk_en),
        .sclk_o(adc_sclk_o), .rise_o(sclk_rise), .fall_o(sclk_fall)
    );

    sadc_edge_sync #(.STAGES(SYNC_STAGES)) u_strobe (
        .clk(clk), .rst(rst), .async_i(adc_sstrb_i), .fall_o(strobe_fall)
    );

    sadc_result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_bank (
        .clk(clk), .rst(rst), .we_i(bank_we), .waddr_i(cfg_q.chan),
        .wdata_i(frame_q[FRAME_W-1 -: RES_W]), .raddr_i(rf_rd_idx_i),
        .rdata_o(rf_rd_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cfg_q       <= '0;
            scan_q      <= 1'b0;
            fail_q      <= 1'b0;
            timeout_q   <= 1'b0;
            done_q      <= 1'b0;
            scan_done_q <= 1'b0;
            cs_n_q      <= 1'b1;
            din_q       <= 1'b0;
            ctrl_sr_q   <= '0;
            bit_cnt_q   <= '0;
            to_cnt_q    <= '0;
            frame_q     <= '0;
            result_q    <= '0;
        end else begin
            done_q      <= 1'b0;
            scan_done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cfg_q     <= start_cfg;
                        scan_q    <= scan_i;
                        fail_q    <= 1'b0;
                        timeout_q <= 1'b0;
                        ctrl_sr_q <= start_ctrl;
                        din_q     <= start_ctrl[CTRL_W-1];
                        cs_n_q    <= 1'b0;
                        bit_cnt_q <= '0;
                        state_q   <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (sclk_fall) begin
                        ctrl_sr_q <= ctrl_sr_q << 1;
                        din_q     <= ctrl_sr_q[CTRL_W-2];
                    end
                    if (sclk_rise) begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                        if (bit_cnt_q == BIT_W'(CTRL_W - 1)) begin
                            to_cnt_q <= '0;
                            state_q  <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (sclk_fall) din_q <= 1'b0;
                    if (strobe_fall) begin
                        bit_cnt_q <= '0;
                        state_q   <= ST_READ;
                    end else if (sclk_rise) begin
                        if (to_cnt_q == TO_W'(TIMEOUT_SCLKS - 1)) begin
                            fail_q  <= 1'b1;
                            state_q <= ST_FINISH;
                        end else begin
                            to_cnt_q <= to_cnt_q + 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (sclk_rise) begin
                        frame_q   <= {frame_q[FRAME_W-2:0], adc_dout_i};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                        if (bit_cnt_q == BIT_W'(FRAME_W - 1)) state_q <= ST_FINISH;
                    end
                end
                ST_FINISH: begin
                    if (sclk_fall) begin
                        cs_n_q <= 1'b1;
                        if (fail_q) timeout_q <= 1'b1;
                        else        result_q  <= frame_q[FRAME_W-1 -: RES_W];
                        if (scan_q && !fail_q && cfg_q.chan != LAST_CH) begin
                            cfg_q.chan <= cfg_q.chan + 1'b1;
                            state_q    <= ST_GAP;
                        end else begin
                            done_q      <= 1'b1;
                            scan_done_q <= scan_q && !fail_q;
                            state_q     <= ST_IDLE;
                        end
                    end
                end
                ST_GAP: begin
                    ctrl_sr_q <= next_ctrl;
                    din_q     <= next_ctrl[CTRL_W-1];
                    cs_n_q    <= 1'b0;
                    bit_cnt_q <= '0;
                    state_q   <= ST_SEND;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign scan_done_o = scan_done_q;
    assign timeout_o   = timeout_q;
    assign result_o    = result_q;
    assign adc_cs_n_o  = cs_n_q;
    assign adc_din_o   = din_q;

    // R10
    idle_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> adc_cs_n_o);
    // R3
    sclk_low_when_deselected_chk: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n_o |-> !adc_sclk_o);
    // R2
    start_bit_set_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEND && bit_cnt_q == '0 && sclk_rise) |-> adc_din_o);
    // R5
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R8
    scan_done_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        scan_done_o |-> done_o);
    // R5
    result_moves_at_release_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_o) |-> $rose(adc_cs_n_o));
    // R6
    start_while_busy_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEND && start_i) |=> $stable(cfg_q));

endmodule

// File: tb/serial_adc_ctl_tb.sv
`timescale 1ns/1ps
module serial_adc_ctl_tb;
    localparam int DIV = 6;
    localparam int TMO = 20;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst = 1'b1, start_i = 1'b0, scan_i = 1'b0;
    logic [2:0]  chan_i = '0, rf_rd_idx_i = '0;
    logic        unipolar_i = 1'b0, single_ended_i = 1'b0;
    logic        busy_o, done_o, scan_done_o, timeout_o;
    logic [11:0] result_o, rf_rd_data_o;
    logic        adc_cs_n_o, adc_sclk_o, adc_din_o;
    logic        adc_sstrb_i = 1'b1, adc_dout_i = 1'b0;

    serial_adc_ctl #(.DIV_HALF(DIV), .TIMEOUT_SCLKS(TMO)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .scan_i(scan_i), .chan_i(chan_i),
        .unipolar_i(unipolar_i), .single_ended_i(single_ended_i),
        .rf_rd_idx_i(rf_rd_idx_i), .busy_o(busy_o), .done_o(done_o),
        .scan_done_o(scan_done_o), .timeout_o(timeout_o), .result_o(result_o),
        .rf_rd_data_o(rf_rd_data_o), .adc_cs_n_o(adc_cs_n_o), .adc_sclk_o(adc_sclk_o),
        .adc_din_o(adc_din_o), .adc_sstrb_i(adc_sstrb_i), .adc_dout_i(adc_dout_i)
    );

    int n_chk = 0, n_fail = 0;
    logic [11:0] model_val [8];
    logic [11:0] bank_exp [8];
    int          str_delay = 1;
    bit          no_strobe = 0;
    logic [7:0]  ctrl_log [64];
    int          ctrl_cnt = 0;
    realtime     period_meas = 0;
    bit          saw_done, saw_scan_done, saw_timeout;

    function automatic logic [7:0] exp_ctrl(logic [2:0] ch, logic uni, logic sgl);
        return {1'b1, ch, uni, sgl, 2'b11};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Converter model: decodes the control byte, answers after str_delay falling edges.
    initial begin
        forever begin
            logic [7:0]  cbyte;
            logic [15:0] frame;
            @(negedge adc_cs_n_o);
            cbyte = '0;
            for (int i = 0; i < 8; i++) begin
                @(posedge adc_sclk_o);
                cbyte = {cbyte[6:0], adc_din_o};
            end
            if (ctrl_cnt < 64) ctrl_log[ctrl_cnt] = cbyte;
            ctrl_cnt++;
            if (!no_strobe) begin
                for (int i = 0; i < str_delay; i++) @(negedge adc_sclk_o);
                frame = {model_val[cbyte[6:4]], 4'($urandom)};
                adc_sstrb_i = 1'b0;
                adc_dout_i  = frame[15];
                for (int i = 14; i >= 0; i--) begin
                    @(negedge adc_sclk_o);
                    adc_dout_i = frame[i];
                end
            end
            @(posedge adc_cs_n_o);
            adc_sstrb_i = 1'b1;
            adc_dout_i  = 1'b0;
        end
    end

    initial begin
        forever begin
            realtime t0;
            @(negedge adc_cs_n_o);
            @(posedge adc_sclk_o);
            t0 = $realtime;
            @(posedge adc_sclk_o);
            period_meas = $realtime - t0;
        end
    end

    task automatic pulse_start(logic [2:0] ch, logic uni, logic sgl, logic scan);
        @(negedge clk);
        chan_i = ch; unipolar_i = uni; single_ended_i = sgl; scan_i = scan; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; scan_i = 1'b0;
    endtask

    task automatic wait_done();
        saw_done = 0;
        for (int i = 0; i < 20000 && !saw_done; i++) begin
            @(negedge clk);
            if (done_o) begin
                saw_done = 1; saw_scan_done = scan_done_o; saw_timeout = timeout_o;
            end
        end
        check(saw_done, "R5 done seen", 32'(saw_done), 1);
        check(!busy_o && adc_cs_n_o, "R5 released with done", {busy_o, adc_cs_n_o}, 2'b01);
        @(negedge clk);
        check(!done_o, "R5 done width one cycle", 32'(done_o), 0);
    endtask

    task automatic check_bank(string req);
        for (int i = 0; i < 8; i++) begin
            rf_rd_idx_i = 3'(i);
            #1;
            check(rf_rd_data_o == bank_exp[i], req, rf_rd_data_o, bank_exp[i]);
        end
    endtask

    task automatic single_conv(logic [2:0] ch, logic uni, logic sgl, int dly);
        int c0;
        c0 = ctrl_cnt;
        model_val[ch] = 12'($urandom);
        str_delay = dly;
        pulse_start(ch, uni, sgl, 1'b0);
        check(busy_o && !adc_cs_n_o, "R10 busy and select after start", {busy_o, adc_cs_n_o}, 2'b10);
        wait_done();
        bank_exp[ch] = model_val[ch];
        check(ctrl_cnt == c0 + 1, "R2 one control byte", ctrl_cnt, c0 + 1);
        check(ctrl_log[c0] == exp_ctrl(ch, uni, sgl), "R2 control byte", ctrl_log[c0], exp_ctrl(ch, uni, sgl));
        check(result_o == model_val[ch], "R4 result bits", result_o, model_val[ch]);
        check(!saw_timeout && !timeout_o, "R7 no timeout", timeout_o, 0);
        rf_rd_idx_i = ch;
        #1;
        check(rf_rd_data_o == model_val[ch], "R9 bank written", rf_rd_data_o, model_val[ch]);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0a1c));
        for (int i = 0; i < 8; i++) begin model_val[i] = '0; bank_exp[i] = '0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(adc_cs_n_o && !adc_sclk_o && !adc_din_o, "R1 pins after reset",
              {adc_cs_n_o, adc_sclk_o, adc_din_o}, 3'b100);
        check(!busy_o && !done_o && !scan_done_o && !timeout_o, "R1 flags after reset",
              {busy_o, done_o, scan_done_o, timeout_o}, 0);
        check(result_o == 0, "R1 result after reset", result_o, 0);
        check_bank("R1 bank after reset");

        // Directed corners
        single_conv(3'd5, 1'b1, 1'b0, 1);
        check(period_meas == 2.0 * DIV * 5.0, "R3 sclk period", 32'(int'(period_meas)), 2 * DIV * 5);
        single_conv(3'd0, 1'b0, 1'b1, TMO);   // R7 strobe in last half-period accepted
        single_conv(3'd7, 1'b1, 1'b1, 3);

        // Random singles
        for (int k = 0; k < 8; k++)
            single_conv(3'($urandom), 1'($urandom), 1'($urandom), 1 + int'($urandom % TMO));

        // R6 start during a conversion is ignored
        begin
            int c0;
            c0 = ctrl_cnt;
            model_val[2] = 12'($urandom);
            str_delay = 4;
            pulse_start(3'd2, 1'b0, 1'b0, 1'b0);
            repeat (30) @(negedge clk);
            pulse_start(3'd6, 1'b1, 1'b1, 1'b1);
            wait_done();
            bank_exp[2] = model_val[2];
            check(ctrl_cnt == c0 + 1, "R6 extra start ignored", ctrl_cnt, c0 + 1);
            check(ctrl_log[c0] == exp_ctrl(3'd2, 1'b0, 1'b0), "R6 channel kept", ctrl_log[c0], exp_ctrl(3'd2, 1'b0, 1'b0));
            check(!saw_scan_done, "R6 no scan", saw_scan_done, 0);
        end

        // R7 timeout: strobe never falls
        begin
            logic [11:0] prev;
            prev = result_o;
            no_strobe = 1;
            model_val[4] = 12'($urandom);
            pulse_start(3'd4, 1'b0, 1'b1, 1'b0);
            wait_done();
            no_strobe = 0;
            check(saw_timeout && timeout_o, "R7 timeout flagged", timeout_o, 1);
            check(result_o == prev, "R7 result kept", result_o, prev);
            check_bank("R7 bank kept");
            single_conv(3'd1, 1'b0, 1'b0, 2);   // clears timeout (checked inside)
        end

        // R8 scan of all channels
        begin
            int c0;
            c0 = ctrl_cnt;
            for (int i = 0; i < 8; i++) model_val[i] = 12'($urandom);
            str_delay = 2;
            pulse_start(3'd3, 1'b1, 1'b0, 1'b1);
            saw_done = 0;
            for (int i = 0; i < 60000 && !saw_done; i++) begin
                @(negedge clk);
                if (!saw_done && !done_o && !busy_o) begin
                    check(0, "R10 busy dropped inside scan", 0, 1);
                    saw_done = 1;
                end
                if (done_o) begin saw_done = 1; saw_scan_done = scan_done_o; end
            end
            check(saw_scan_done, "R8 scan_done with done", saw_scan_done, 1);
            check(ctrl_cnt == c0 + 8, "R8 eight conversions", ctrl_cnt, c0 + 8);
            for (int i = 0; i < 8; i++) begin
                check(ctrl_log[c0 + i] == exp_ctrl(3'(i), 1'b1, 1'b0), "R8 channel order",
                      ctrl_log[c0 + i], exp_ctrl(3'(i), 1'b1, 1'b0));
                bank_exp[i] = model_val[i];
            end
            check(result_o == model_val[7], "R4 scan final result", result_o, model_val[7]);
            check_bank("R9 scan bank");
        end

        finish_run();
    end

endmodule